// File: doc/BRIEF.md
# Simultaneous-Sampling ADC Capture Controller

This block runs one acquisition per sample tick on an eight-channel, 16-bit bipolar converter that samples all of its channels at the same instant. On a tick it pulses the conversion-start line for a fixed number of system clocks. It then follows the converter's busy line high and back low and waits for the frame-sync line. After a programmable lead time it drives a serial clock for one 32-bit frame. Four serial data lanes are shifted in together, and each lane holds two channels, one after the other.

When the frame is complete, the eight channels appear as two's-complement words on a flat output bus. They are marked by a single-cycle valid strobe. If the busy or frame-sync handshake stalls longer than a programmable limit, the controller drops the capture, pulses an error flag and goes back to idle. A tick that arrives while a capture is running does not start anything and increments an overrun counter.

Top module: `adc_simul_capture`

## Requirements
- R1: After reset, conv_start, sclk, sample_valid and timeout_err are low and overrun_cnt is zero.
- R2: A sample_tick seen while idle raises conv_start for exactly CONV_PULSE consecutive clock cycles. sclk stays low while conv_start is high.
- R3: No rising sclk edge occurs while the synchronized busy input is high, and none occurs before frame_sync has been seen high.
- R4: Each capture produces exactly 32 sclk periods. Every high phase lasts SCLK_HALF clock cycles.
- R5: Data is sampled on the falling sclk edge and shifted MSB first. Lane k holds channel 2k in its first 16 bits and channel 2k+1 in its last 16 bits. Channel c appears on samples[16c+15:16c] as a two's-complement value.
- R6: sample_valid is a one-cycle pulse that comes after the 32nd falling sclk edge, once per completed capture.
- R7: If busy does not rise within TIMEOUT cycles of the end of the start pulse, timeout_err pulses for one cycle, no sclk edge and no sample_valid are produced, and the next tick starts a fresh capture.
- R8: If frame_sync does not rise within TIMEOUT cycles of busy falling, timeout_err pulses for one cycle, no sclk edge and no sample_valid are produced, and the next tick starts a fresh capture.
- R9: A sample_tick that arrives while a capture is in progress does not disturb it and increments overrun_cnt. With OVR_SATURATE=1 the counter holds at its all-ones value.
- R10: A sample_tick in the same cycle as the sample_valid pulse is accepted as a new capture and is not counted as an overrun.
- R11: At least FS_LEAD+1 clock cycles pass between frame_sync rising and the first rising sclk edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_tick | input | 1 | Periodic request to start one acquisition |
| conv_start | output | 1 | Conversion-start pulse to the converter |
| conv_busy | input | 1 | Converter busy; high while converting |
| frame_sync | input | 1 | Converter signal that serial data is ready |
| sclk | output | 1 | Serial clock to the converter |
| sdata | input | LANES (4) | Serial data lanes, one bit per lane |
| samples | output | CHANNELS*SAMPLE_W (128) | Eight signed samples, channel c at bits 16c+15:16c |
| sample_valid | output | 1 | One-cycle strobe when samples are updated |
| timeout_err | output | 1 | One-cycle strobe when a handshake timed out |
| overrun_cnt | output | OVR_W (8) | Count of ticks ignored during a capture |

## Verification
The completion of one capture and the tick that requests the next can land in the same cycle. The bench provokes this by raising sample_tick in exactly the cycle where sample_valid is observed high. It judges the outcome by checking that conv_start rises on the next edge and that overrun_cnt does not change. Ticks placed in the middle of the busy phase, by contrast, must each increment the counter, which saturates at three in the reduced-width bench configuration, and must leave the delivered samples intact. Timeouts on either handshake are interleaved with these cases so that recovery into a normal capture is also observed.

// File: rtl/adcc_pkg.sv
package adcc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_CONV    = 3'd1,
      ST_BSY_ON  = 3'd2,
      ST_BSY_OFF = 3'd3,
      ST_FS_WAIT = 3'd4,
      ST_LEAD    = 3'd5,
      ST_SHIFT   = 3'd6,
      ST_DONE    = 3'd7
   } adcc_state_e;

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/adcc_sync.sv
module adcc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else if (STAGES == 1) begin : g_one
         logic r_q;
         always_ff @(posedge clk) begin
            if (!rst_n) r_q <= 1'b0;
            else        r_q <= d_i;
         end
         assign q_o = r_q;
      end else begin : g_chain
         logic [STAGES-1:0] r_q;
         always_ff @(posedge clk) begin
            if (!rst_n) r_q <= '0;
            else        r_q <= {r_q[STAGES-2:0], d_i};
         end
         assign q_o = r_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/adcc_sclk_gen.sv
module adcc_sclk_gen #(
   parameter int HALF       = 2,
   parameter int FRAME_BITS = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic sclk_o,
   output logic smp_stb_o,
   output logic last_stb_o
);

   localparam int PH_W  = (HALF > 1) ? $clog2(HALF) : 1;
   localparam int BIT_W = $clog2(FRAME_BITS);

   logic [PH_W-1:0]  ph_q;
   logic [BIT_W-1:0] bit_q;
   logic             sclk_q;
   logic             ph_end;

   assign ph_end     = (ph_q == PH_W'(HALF - 1));
   assign smp_stb_o  = run_i && ph_end && sclk_q;
   assign last_stb_o = smp_stb_o && (bit_q == BIT_W'(FRAME_BITS - 1));
   assign sclk_o     = sclk_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !run_i) begin
         ph_q   <= '0;
         bit_q  <= '0;
         sclk_q <= 1'b0;
      end else if (ph_end) begin
         ph_q   <= '0;
         sclk_q <= ~sclk_q;
         if (sclk_q) bit_q <= bit_q + 1'b1;
      end else begin
         ph_q <= ph_q + 1'b1;
      end
   end

endmodule

// File: rtl/adcc_lane_shift.sv
module adcc_lane_shift #(
   parameter int FRAME_BITS = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  stb_i,
   input  logic                  din_i,
   output logic [FRAME_BITS-1:0] word_o
);

   logic [FRAME_BITS-1:0] sr_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     sr_q <= '0;
      else if (stb_i) sr_q <= {sr_q[FRAME_BITS-2:0], din_i};
   end

   assign word_o = sr_q;

endmodule

// File: rtl/adcc_seq.sv
module adcc_seq
   import adcc_pkg::*;
#(
   parameter int CONV_PULSE = 4,
   parameter int FS_LEAD    = 2,
   parameter int TIMEOUT    = 512
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        tick_i,
   input  logic        busy_i,
   input  logic        fs_i,
   input  logic        last_stb_i,
   output logic        conv_start_o,
   output logic        run_shift_o,
   output logic        done_o,
   output logic        err_o,
   output logic        tick_ign_o
);

   localparam int TMAX  = int'(max3(CONV_PULSE, FS_LEAD, TIMEOUT));
   localparam int TMR_W = $clog2(TMAX + 1);

   adcc_state_e      st_q;
   logic [TMR_W-1:0] tmr_q;
   logic             conv_q;
   logic             err_q;
   logic             tmo_hit;

   assign tmo_hit      = (tmr_q == TMR_W'(TIMEOUT - 1));
   assign conv_start_o = conv_q;
   assign run_shift_o  = (st_q == ST_SHIFT);
   assign done_o       = (st_q == ST_DONE);
   assign err_o        = err_q;
   assign tick_ign_o   = tick_i && (st_q != ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         tmr_q  <= '0;
         conv_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         err_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (tick_i) begin
                  st_q   <= ST_CONV;
                  tmr_q  <= '0;
                  conv_q <= 1'b1;
               end
            end
            ST_CONV: begin
               if (tmr_q == TMR_W'(CONV_PULSE - 1)) begin
                  conv_q <= 1'b0;
                  st_q   <= ST_BSY_ON;
                  tmr_q  <= '0;
               end else begin
                  tmr_q <= tmr_q + 1'b1;
               end
            end
            ST_BSY_ON: begin
               if (busy_i) begin
                  st_q  <= ST_BSY_OFF;
                  tmr_q <= '0;
               end else if (tmo_hit) begin
                  st_q  <= ST_IDLE;
                  err_q <= 1'b1;
               end else begin
                  tmr_q <= tmr_q + 1'b1;
               end
            end
            ST_BSY_OFF: begin
               if (!busy_i) begin
                  st_q  <= ST_FS_WAIT;
                  tmr_q <= '0;
               end else if (tmo_hit) begin
                  st_q  <= ST_IDLE;
                  err_q <= 1'b1;
               end else begin
                  tmr_q <= tmr_q + 1'b1;
               end
            end
            ST_FS_WAIT: begin
               if (fs_i) begin
                  st_q  <= ST_LEAD;
                  tmr_q <= '0;
               end else if (tmo_hit) begin
                  st_q  <= ST_IDLE;
                  err_q <= 1'b1;
               end else begin
                  tmr_q <= tmr_q + 1'b1;
               end
            end
            ST_LEAD: begin
               if (tmr_q == TMR_W'(FS_LEAD - 1)) begin
                  st_q  <= ST_SHIFT;
                  tmr_q <= '0;
               end else begin
                  tmr_q <= tmr_q + 1'b1;
               end
            end
            ST_SHIFT: begin
               if (last_stb_i) st_q <= ST_DONE;
            end
            ST_DONE: begin
               st_q <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/adc_simul_capture.sv
module adc_simul_capture #(
   parameter int LANES        = 4,
   parameter int CH_PER_LANE  = 2,
   parameter int SAMPLE_W     = 16,
   parameter int SCLK_HALF    = 2,
   parameter int CONV_PULSE   = 4,
   parameter int FS_LEAD      = 2,
   parameter int TIMEOUT      = 512,
   parameter int SYNC_STAGES  = 2,
   parameter int OVR_W        = 8,
   parameter bit OVR_SATURATE = 1'b1,
   localparam int CHANNELS    = LANES * CH_PER_LANE
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         sample_tick,
   output logic                         conv_start,
   input  logic                         conv_busy,
   input  logic                         frame_sync,
   output logic                         sclk,
   input  logic [LANES-1:0]             sdata,
   output logic [CHANNELS*SAMPLE_W-1:0] samples,
   output logic                         sample_valid,
   output logic                         timeout_err,
   output logic [OVR_W-1:0]             overrun_cnt
);

   localparam int FRAME_BITS = CH_PER_LANE * SAMPLE_W;

   initial begin : p_param_chk
      assert (SCLK_HALF >= 1)  else $error("SCLK_HALF must be at least 1");
      assert (CONV_PULSE >= 1) else $error("CONV_PULSE must be at least 1");
      assert (FS_LEAD >= 1)    else $error("FS_LEAD must be at least 1");
      assert (TIMEOUT >= 2)    else $error("TIMEOUT must be at least 2");
      assert (FRAME_BITS >= 2) else $error("frame must hold at least two bits");
      assert (OVR_W >= 1)      else $error("OVR_W must be at least 1");
   end

   logic busy_s, fs_s;
   logic run_shift, smp_stb, last_stb;
   logic done, tick_ign;
   logic valid_q;
   logic [OVR_W-1:0] ovr_q;

   adcc_sync #(.STAGES(SYNC_STAGES)) u_sync_busy (
      .clk(clk), .rst_n(rst_n), .d_i(conv_busy), .q_o(busy_s)
   );

   adcc_sync #(.STAGES(SYNC_STAGES)) u_sync_fs (
      .clk(clk), .rst_n(rst_n), .d_i(frame_sync), .q_o(fs_s)
   );

   adcc_seq #(
      .CONV_PULSE(CONV_PULSE),
      .FS_LEAD   (FS_LEAD),
      .TIMEOUT   (TIMEOUT)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_i      (sample_tick),
      .busy_i      (busy_s),
      .fs_i        (fs_s),
      .last_stb_i  (last_stb),
      .conv_start_o(conv_start),
      .run_shift_o (run_shift),
      .done_o      (done),
      .err_o       (timeout_err),
      .tick_ign_o  (tick_ign)
   );

   adcc_sclk_gen #(
      .HALF      (SCLK_HALF),
      .FRAME_BITS(FRAME_BITS)
   ) u_sclk (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (run_shift),
      .sclk_o    (sclk),
      .smp_stb_o (smp_stb),
      .last_stb_o(last_stb)
   );

   generate
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         logic [FRAME_BITS-1:0] word;

         adcc_lane_shift #(.FRAME_BITS(FRAME_BITS)) u_shift (
            .clk   (clk),
            .rst_n (rst_n),
            .stb_i (smp_stb),
            .din_i (sdata[k]),
            .word_o(word)
         );

         for (genvar j = 0; j < CH_PER_LANE; j++) begin : g_ch
            logic [SAMPLE_W-1:0] ch_q;
            always_ff @(posedge clk) begin
               if (!rst_n)    ch_q <= '0;
               else if (done) ch_q <= word[FRAME_BITS-1-j*SAMPLE_W -: SAMPLE_W];
            end
            assign samples[(k*CH_PER_LANE+j)*SAMPLE_W +: SAMPLE_W] = ch_q;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) valid_q <= 1'b0;
      else        valid_q <= done;
   end
   assign sample_valid = valid_q;

   generate
      if (OVR_SATURATE) begin : g_ovr_sat
         always_ff @(posedge clk) begin
            if (!rst_n)                       ovr_q <= '0;
            else if (tick_ign && ovr_q != '1) ovr_q <= ovr_q + 1'b1;
         end
      end else begin : g_ovr_wrap
         always_ff @(posedge clk) begin
            if (!rst_n)        ovr_q <= '0;
            else if (tick_ign) ovr_q <= ovr_q + 1'b1;
         end
      end
   endgenerate
   assign overrun_cnt = ovr_q;

endmodule

// File: rtl/adcc_chk.sv
module adcc_chk #(
   parameter int HALF       = 2,
   parameter int CONV_PULSE = 4,
   parameter int OVR_W      = 8,
   parameter bit OVR_SAT    = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             conv_start,
   input logic             busy_s,
   input logic             sclk,
   input logic             sample_valid,
   input logic             timeout_err,
   input logic [OVR_W-1:0] overrun_cnt
);

   logic [15:0] hi_run_q;
   logic [15:0] cs_run_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_run_q <= '0;
         cs_run_q <= '0;
      end else begin
         hi_run_q <= sclk ? ((hi_run_q == 16'hFFFF) ? hi_run_q : hi_run_q + 1'b1) : '0;
         cs_run_q <= conv_start ? ((cs_run_q == 16'hFFFF) ? cs_run_q : cs_run_q + 1'b1) : '0;
      end
   end

   AST_CONV_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(conv_start) |-> cs_run_q == 16'(CONV_PULSE)); // R2
   AST_CONV_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> !sclk); // R2
   AST_SCLK_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk) |-> !busy_s); // R3
   AST_SCLK_HIGH_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sclk) |-> hi_run_q == 16'(HALF)); // R4
   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      sample_valid |=> !sample_valid); // R6
   AST_ERR_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_err |-> !sample_valid && !sclk); // R7
   AST_OVR_MONOTONE: assert property (@(posedge clk) disable iff (!rst_n)
      !OVR_SAT || !(overrun_cnt < $past(overrun_cnt))); // R9

endmodule

bind adc_simul_capture adcc_chk #(
   .HALF      (SCLK_HALF),
   .CONV_PULSE(CONV_PULSE),
   .OVR_W     (OVR_W),
   .OVR_SAT   (OVR_SATURATE)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .conv_start  (conv_start),
   .busy_s      (busy_s),
   .sclk        (sclk),
   .sample_valid(sample_valid),
   .timeout_err (timeout_err),
   .overrun_cnt (overrun_cnt)
);

// File: tb/adc_simul_capture_tb.sv
`timescale 1ns/1ps
module adc_simul_capture_tb_top;

   localparam int LANES   = 4;
   localparam int CH      = 8;
   localparam int W       = 16;
   localparam int HALF    = 2;
   localparam int CPULSE  = 3;
   localparam int LEAD    = 2;
   localparam int TMO     = 80;
   localparam int OVRW    = 2;
   localparam int OVR_MAX = 3;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               sample_tick = 1'b0;
   logic               conv_busy = 1'b0;
   logic               frame_sync = 1'b0;
   logic [LANES-1:0]   sdata = '0;
   logic               conv_start, sclk, sample_valid, timeout_err;
   logic [CH*W-1:0]    samples;
   logic [OVRW-1:0]    overrun_cnt;

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;
   int n_rise   = 0;
   int exp_ovr  = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;
   always @(posedge sclk) n_rise <= n_rise + 1;

   adc_simul_capture #(
      .LANES(LANES), .CH_PER_LANE(2), .SAMPLE_W(W), .SCLK_HALF(HALF),
      .CONV_PULSE(CPULSE), .FS_LEAD(LEAD), .TIMEOUT(TMO), .SYNC_STAGES(2),
      .OVR_W(OVRW), .OVR_SATURATE(1'b1)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .conv_start(conv_start),
      .conv_busy(conv_busy), .frame_sync(frame_sync), .sclk(sclk), .sdata(sdata),
      .samples(samples), .sample_valid(sample_valid), .timeout_err(timeout_err),
      .overrun_cnt(overrun_cnt)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   function automatic logic lane_bit(input logic [CH*W-1:0] v, input int k, input int b);
      logic [2*W-1:0] word;
      word = {v[(2*k)*W +: W], v[(2*k+1)*W +: W]};
      return word[2*W-1-b];
   endfunction

   function automatic int sat_add(input int a, input int n);
      return (a + n > OVR_MAX) ? OVR_MAX : a + n;
   endfunction

   // mode 0: normal, 1: busy never rises, 2: frame_sync never rises
   task automatic run_capture(input logic [CH*W-1:0] vals, input int mode,
                              input int n_ovr, input bit pre_started, input bit chain);
      int width, blen, rise0, fs_cyc, rise_cyc, guard;
      bit seen;
      if (!pre_started) begin
         @(negedge clk); sample_tick = 1'b1;
         @(negedge clk); sample_tick = 1'b0;
      end
      width = 0;
      while (conv_start && width < 100) begin width++; @(negedge clk); end
      chk(width == CPULSE, "R2 conv_start width", width, CPULSE);
      rise0 = n_rise;
      if (mode == 1) begin
         seen = 1'b0;
         for (int i = 0; i < TMO + 20; i++) begin
            @(negedge clk);
            if (timeout_err) seen = 1'b1;
            if (sample_valid) chk(1'b0, "R7 valid during busy timeout", 1, 0);
         end
         chk(seen, "R7 timeout_err on missing busy", seen, 1);
         chk(n_rise == rise0, "R7 no sclk on busy timeout", n_rise - rise0, 0);
         return;
      end
      blen = 10 + int'($urandom_range(30));
      conv_busy = 1'b1;
      for (int i = 0; i < blen; i++) begin
         sample_tick = (i % 2 == 0) && (i / 2 < n_ovr);
         @(negedge clk);
      end
      sample_tick = 1'b0;
      conv_busy = 1'b0;
      exp_ovr = sat_add(exp_ovr, n_ovr);
      if (mode == 2) begin
         seen = 1'b0;
         for (int i = 0; i < TMO + 20; i++) begin
            @(negedge clk);
            if (timeout_err) seen = 1'b1;
            if (sample_valid) chk(1'b0, "R8 valid during sync timeout", 1, 0);
         end
         chk(seen, "R8 timeout_err on missing frame_sync", seen, 1);
         chk(n_rise == rise0, "R8 no sclk on sync timeout", n_rise - rise0, 0);
         chk(overrun_cnt == OVRW'(exp_ovr), "R9 overrun count", overrun_cnt, exp_ovr);
         return;
      end
      repeat (int'($urandom_range(5))) @(negedge clk);
      chk(n_rise == rise0, "R3 sclk before frame_sync", n_rise - rise0, 0);
      frame_sync = 1'b1;
      fs_cyc = cyc;
      rise_cyc = 0;
      for (int b = 0; b < 2*W; b++) begin
         @(posedge sclk);
         #1;
         if (b == 0) rise_cyc = cyc;
         for (int k = 0; k < LANES; k++) sdata[k] = lane_bit(vals, k, b);
      end
      chk(rise_cyc - fs_cyc >= LEAD + 1, "R11 lead before first sclk", rise_cyc - fs_cyc, LEAD + 1);
      guard = 0;
      @(negedge clk);
      while (!sample_valid && guard < 50) begin guard++; @(negedge clk); end
      chk(sample_valid, "R6 sample_valid after frame", sample_valid, 1);
      chk(n_rise - rise0 == 2*W, "R4 sclk period count", n_rise - rise0, 2*W);
      for (int c = 0; c < CH; c++)
         chk($signed(samples[c*W +: W]) == $signed(vals[c*W +: W]),
             $sformatf("R5 channel %0d", c),
             longint'($signed(samples[c*W +: W])), longint'($signed(vals[c*W +: W])));
      chk(overrun_cnt == OVRW'(exp_ovr), "R9 overrun count", overrun_cnt, exp_ovr);
      if (chain) sample_tick = 1'b1;
      @(negedge clk);
      sample_tick = 1'b0;
      frame_sync = 1'b0;
      sdata = '0;
      chk(!sample_valid, "R6 valid is one cycle", sample_valid, 0);
      if (chain) begin
         chk(conv_start, "R10 tick with valid starts capture", conv_start, 1);
         chk(overrun_cnt == OVRW'(exp_ovr), "R10 no overrun on valid-cycle tick",
             overrun_cnt, exp_ovr);
      end
   endtask

   function automatic logic [CH*W-1:0] rand_vals();
      logic [CH*W-1:0] v;
      for (int c = 0; c < CH; c++) v[c*W +: W] = W'($urandom);
      return v;
   endfunction

   initial begin : p_main
      int seed_init;
      seed_init = $urandom(32'h5EED);
      repeat (4) @(negedge clk);
      chk(!conv_start, "R1 conv_start reset", conv_start, 0);
      chk(!sclk, "R1 sclk reset", sclk, 0);
      chk(!sample_valid, "R1 valid reset", sample_valid, 0);
      chk(!timeout_err, "R1 error reset", timeout_err, 0);
      chk(overrun_cnt == '0, "R1 overrun reset", overrun_cnt, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      run_capture({16'hEDCB, 16'h1234, 16'hFFFE, 16'h0001,
                   16'hFFFF, 16'h0000, 16'h7FFF, 16'h8000}, 0, 0, 1'b0, 1'b0);
      for (int i = 0; i < 5; i++) run_capture(rand_vals(), 0, i % 2, 1'b0, 1'b0);
      run_capture(rand_vals(), 0, 0, 1'b0, 1'b1);
      run_capture(rand_vals(), 0, 0, 1'b1, 1'b0);
      run_capture(rand_vals(), 1, 0, 1'b0, 1'b0);
      run_capture(rand_vals(), 0, 0, 1'b0, 1'b0);
      run_capture(rand_vals(), 2, 0, 1'b0, 1'b0);
      run_capture(rand_vals(), 0, 0, 1'b0, 1'b0);
      run_capture(rand_vals(), 0, 5, 1'b0, 1'b0);
      chk(overrun_cnt == OVRW'(OVR_MAX), "R9 overrun saturates", overrun_cnt, OVR_MAX);
      run_capture({8{16'h8001}}, 0, 0, 1'b0, 1'b0);

      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin : p_watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL R6 watchdog actual=hung expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule